// File: doc/BRIEF.md
# Leakage-Based MLC Page Recovery Engine

This engine repairs a page of two-bit-per-cell flash after error correction has declared it uncorrectable and the data has been saved elsewhere. It runs offline and is never part of an ordinary read. For every cell it receives two threshold-voltage codes. The first is taken when the failure is found. The second is taken after the page has been left to lose more charge. Cells whose first code falls in a band around the optimal boundary between the two highest programmed states are treated as ambiguous. For each such cell, the distance its voltage has fallen between the two samples decides which side of the boundary it started on. A cell that loses charge slowly is assigned the lower of the two states, and a cell that loses charge fast is assigned the higher one. Every other cell keeps the state that a plain threshold comparison of its first code gives. The repaired page then goes back to the decoder.

Cells flow in and out as valid/ready streams, one cell per cycle, in the same order. A cell moves from the input when `in_valid` and `in_ready` are both high at a clock edge. A result leaves when `out_valid` and `out_ready` are both high. While `out_ready` is low, the pending result stays on the output unchanged. Once every pipeline slot is full, `in_ready` drops. The configuration pins are plain levels. Each cell is classified with the values they hold in the cycle that cell is accepted. At the end of each page the engine reports two counts: how many cells were ambiguous, and how many of those received a state different from the plain comparison.

Top module: `leak_recover_top`

## Requirements
- R1: A cell outside the ambiguous band is coded from its first sample v0. If v0 >= cfg_opt the code is 01. Otherwise, if v0 >= cfg_ref_mid the code is 00. Otherwise, if v0 >= cfg_ref_lo the code is 10. Otherwise the code is 11. Such a cell has out_risky = 0 and out_moved = 0.
- R2: A cell is ambiguous (out_risky = 1) when cfg_opt - cfg_sigma <= v0 <= cfg_opt + cfg_sigma. Both edges are included. The bounds are computed without wrap-around: a lower bound below zero acts as 0, and an upper bound above 255 covers up to 255.
- R3: An ambiguous cell whose drop (v0 - v1 when v0 > v1, else 0) is at most cfg_drop_thr is given code 00. This includes any cell whose second sample is not lower than its first.
- R4: An ambiguous cell whose drop exceeds cfg_drop_thr is given code 01.
- R5: Results leave in the order cells arrived. With out_ready held high, a cell accepted at one edge appears on the output exactly STAGES edges later, and one cell per cycle is sustained.
- R6: While out_valid is high and out_ready is low, out_valid stays high and out_code, out_risky, out_moved and out_last stay stable. in_ready is low only when the output holds a result.
- R7: out_moved is 1 exactly when an ambiguous cell's code differs from its R1 code. In the cycle after the output accepts a cell with out_last = 1, rpt_valid is high for one cycle. In that cycle rpt_risky and rpt_moved carry the page's totals, and counting then restarts from zero for the next page. This also holds when pages of one cell each follow back to back.
- R8: The page counters saturate at 2^CNT_W - 1 and do not wrap.
- R9: After reset, out_valid = 0, rpt_valid = 0, in_ready = 1, and rpt_risky = rpt_moved = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ref_lo | input | VW | Boundary between erased and first programmed state |
| cfg_ref_mid | input | VW | Boundary between first and second programmed state |
| cfg_opt | input | VW | Optimal boundary between the two highest states; centre of the band |
| cfg_sigma | input | VW | Half-width of the ambiguous band |
| cfg_drop_thr | input | VW | Largest drop still treated as slow leakage |
| in_valid | input | 1 | Input cell present |
| in_ready | output | 1 | Engine accepts a cell this cycle |
| in_v0 | input | VW | Voltage code at failure time |
| in_v1 | input | VW | Voltage code after extra retention |
| in_last | input | 1 | Final cell of the page |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Sink accepts the result |
| out_code | output | 2 | Recovered two-bit cell value |
| out_risky | output | 1 | Cell lay in the ambiguous band |
| out_moved | output | 1 | Recovered value differs from plain comparison |
| out_last | output | 1 | Final cell of the page |
| rpt_valid | output | 1 | One-cycle page report strobe |
| rpt_risky | output | CNT_W | Ambiguous cells in the page |
| rpt_moved | output | CNT_W | Reassigned cells in the page |

## Verification
The critical overlap is the end of one page coinciding with the first cell of the next. The report of the closing page must be latched in the same cycle that the counters clear and begin counting the new page's first cell. This is provoked by a stream of one-cell pages presented back to back with the output always ready, so that a last-cell handshake falls on every edge. The bench keeps its own running totals, so each one-cycle report must carry exactly the previous page's counts, with none carried over into the following page. A second overlap, an input acceptance while the output is stalled, is driven by an irregular out_ready pattern and judged by holding each stalled result and comparing it with the following cycle.

// File: rtl/leak_recover_pkg.sv
package leak_recover_pkg;

  // Two-bit cell values, lowest to highest threshold
  typedef enum logic [1:0] {
    ST_ER = 2'b11,
    ST_P1 = 2'b10,
    ST_P2 = 2'b00,
    ST_P3 = 2'b01
  } mlc_state_e;

  // Per-cell result carried down the pipeline
  typedef struct packed {
    logic [1:0] code;
    logic       risky;
    logic       moved;
    logic       last;
  } cell_res_t;

endpackage

// File: rtl/leak_classify.sv
module leak_classify
  import leak_recover_pkg::*;
#(
  parameter int VW = 8
) (
  input  logic [VW-1:0] v0,
  input  logic [VW-1:0] v1,
  input  logic [VW-1:0] ref_lo,
  input  logic [VW-1:0] ref_mid,
  input  logic [VW-1:0] ref_opt,
  input  logic [VW-1:0] sigma,
  input  logic [VW-1:0] drop_thr,
  input  logic          last,
  output cell_res_t     res
);

  logic [VW:0]   win_lo;
  logic [VW:0]   win_hi;
  logic [VW-1:0] drop;
  logic          in_band;
  logic          fast;
  mlc_state_e    plain;
  mlc_state_e    fixed;

  // Band edges in one extra bit so neither end wraps
  assign win_hi = {1'b0, ref_opt} + {1'b0, sigma};
  assign win_lo = (sigma > ref_opt) ? '0 : ({1'b0, ref_opt} - {1'b0, sigma});

  assign in_band = ({1'b0, v0} >= win_lo) && ({1'b0, v0} <= win_hi);

  // Charge lost between the two samples, floored at zero
  assign drop = (v0 > v1) ? (v0 - v1) : '0;
  assign fast = drop > drop_thr;

  always_comb begin
    if (v0 >= ref_opt)      plain = ST_P3;
    else if (v0 >= ref_mid) plain = ST_P2;
    else if (v0 >= ref_lo)  plain = ST_P1;
    else                    plain = ST_ER;
  end

  always_comb begin
    if (in_band) fixed = fast ? ST_P3 : ST_P2;
    else         fixed = plain;
  end

  always_comb begin
    res.code  = fixed;
    res.risky = in_band;
    res.moved = in_band && (fixed != plain);
    res.last  = last;
  end

endmodule

// File: rtl/leak_pipe_reg.sv
module leak_pipe_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);

  logic         vld_q;
  logic [W-1:0] dat_q;

  // Full-throughput slot: refills in the same cycle it drains
  assign up_ready = !vld_q || dn_ready;
  assign dn_valid = vld_q;
  assign dn_data  = dat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (up_ready) begin
      vld_q <= up_valid;
      if (up_valid) dat_q <= up_data;
    end
  end

endmodule

// File: rtl/leak_page_stats.sv
module leak_page_stats #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             risky,
  input  logic             moved,
  input  logic             last,
  output logic             rpt_valid,
  output logic [CNT_W-1:0] rpt_risky,
  output logic [CNT_W-1:0] rpt_moved
);

  logic [CNT_W-1:0] cnt_risky;
  logic [CNT_W-1:0] cnt_moved;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c, input logic inc);
    return (inc && (c != '1)) ? c + 1'b1 : c;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_risky <= '0;
      cnt_moved <= '0;
      rpt_valid <= 1'b0;
      rpt_risky <= '0;
      rpt_moved <= '0;
    end else begin
      rpt_valid <= fire && last;
      if (fire) begin
        if (last) begin
          rpt_risky <= sat_inc(cnt_risky, risky);
          rpt_moved <= sat_inc(cnt_moved, moved);
          cnt_risky <= '0;
          cnt_moved <= '0;
        end else begin
          cnt_risky <= sat_inc(cnt_risky, risky);
          cnt_moved <= sat_inc(cnt_moved, moved);
        end
      end
    end
  end

endmodule

// File: rtl/leak_recover_top.sv
module leak_recover_top
  import leak_recover_pkg::*;
#(
  parameter int VW     = 8,
  parameter int CNT_W  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VW-1:0]    cfg_ref_lo,
  input  logic [VW-1:0]    cfg_ref_mid,
  input  logic [VW-1:0]    cfg_opt,
  input  logic [VW-1:0]    cfg_sigma,
  input  logic [VW-1:0]    cfg_drop_thr,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [VW-1:0]    in_v0,
  input  logic [VW-1:0]    in_v1,
  input  logic             in_last,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [1:0]       out_code,
  output logic             out_risky,
  output logic             out_moved,
  output logic             out_last,
  output logic             rpt_valid,
  output logic [CNT_W-1:0] rpt_risky,
  output logic [CNT_W-1:0] rpt_moved
);

  localparam int RES_W = $bits(cell_res_t);

  cell_res_t        head_res;
  cell_res_t        tail_res;
  logic             vld [STAGES+1];
  logic             rdy [STAGES+1];
  logic [RES_W-1:0] dat [STAGES+1];

  leak_classify #(.VW(VW)) u_classify (
    .v0       (in_v0),
    .v1       (in_v1),
    .ref_lo   (cfg_ref_lo),
    .ref_mid  (cfg_ref_mid),
    .ref_opt  (cfg_opt),
    .sigma    (cfg_sigma),
    .drop_thr (cfg_drop_thr),
    .last     (in_last),
    .res      (head_res)
  );

  assign vld[0]   = in_valid;
  assign in_ready = rdy[0];
  assign dat[0]   = head_res;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    leak_pipe_reg #(.W(RES_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .up_valid (vld[g]),
      .up_ready (rdy[g]),
      .up_data  (dat[g]),
      .dn_valid (vld[g+1]),
      .dn_ready (rdy[g+1]),
      .dn_data  (dat[g+1])
    );
  end

  assign rdy[STAGES] = out_ready;
  assign out_valid   = vld[STAGES];
  assign tail_res    = cell_res_t'(dat[STAGES]);
  assign out_code    = tail_res.code;
  assign out_risky   = tail_res.risky;
  assign out_moved   = tail_res.moved;
  assign out_last    = tail_res.last;

  leak_page_stats #(.CNT_W(CNT_W)) u_stats (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (out_valid && out_ready),
    .risky     (tail_res.risky),
    .moved     (tail_res.moved),
    .last      (tail_res.last),
    .rpt_valid (rpt_valid),
    .rpt_risky (rpt_risky),
    .rpt_moved (rpt_moved)
  );

endmodule

// File: rtl/leak_recover_chk.sv
module leak_recover_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [1:0]       out_code,
  input logic             out_risky,
  input logic             out_moved,
  input logic             out_last,
  input logic             rpt_valid,
  input logic [CNT_W-1:0] rpt_risky,
  input logic [CNT_W-1:0] rpt_moved
);

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_code) && $stable(out_risky)
                                   && $stable(out_moved) && $stable(out_last))); // R6

  AST_FULL_HAS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> out_valid); // R6

  AST_BAND_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_risky) |-> (out_code == 2'b00 || out_code == 2'b01)); // R3

  AST_MOVED_IS_RISKY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_moved) |-> out_risky); // R7

  AST_RPT_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid |-> $past(out_valid && out_ready && out_last)); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid |-> (rpt_moved <= rpt_risky)); // R8

endmodule

bind leak_recover_top leak_recover_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_code  (out_code),
  .out_risky (out_risky),
  .out_moved (out_moved),
  .out_last  (out_last),
  .rpt_valid (rpt_valid),
  .rpt_risky (rpt_risky),
  .rpt_moved (rpt_moved)
);

// File: tb/leak_recover_top_tb_top.sv
module leak_recover_top_tb_top;

  localparam int VW = 8;
  localparam int CW = 4;
  localparam int ST = 2;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic [VW-1:0] cfg_ref_lo, cfg_ref_mid, cfg_opt, cfg_sigma, cfg_drop_thr;
  logic          in_valid, in_ready, in_last;
  logic [VW-1:0] in_v0, in_v1;
  logic          out_valid, out_ready, out_risky, out_moved, out_last;
  logic [1:0]    out_code;
  logic          rpt_valid;
  logic [CW-1:0] rpt_risky, rpt_moved;

  leak_recover_top #(.VW(VW), .CNT_W(CW), .STAGES(ST)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_ref_lo(cfg_ref_lo), .cfg_ref_mid(cfg_ref_mid), .cfg_opt(cfg_opt),
    .cfg_sigma(cfg_sigma), .cfg_drop_thr(cfg_drop_thr),
    .in_valid(in_valid), .in_ready(in_ready), .in_v0(in_v0), .in_v1(in_v1), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_code(out_code),
    .out_risky(out_risky), .out_moved(out_moved), .out_last(out_last),
    .rpt_valid(rpt_valid), .rpt_risky(rpt_risky), .rpt_moved(rpt_moved)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_bad = 0;

  logic [VW-1:0] cv0 [64];
  logic [VW-1:0] cv1 [64];
  bit            clast [64];
  int            acc_cyc [64];
  int            ncell;
  int            stall;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Expected result from the requirements: [1:0] code, [2] risky, [3] moved
  function automatic logic [3:0] model(input logic [VW-1:0] v0, input logic [VW-1:0] v1);
    int lo, hi, drop;
    logic [1:0] plain, code;
    bit risky;
    lo = int'(cfg_opt) - int'(cfg_sigma);
    hi = int'(cfg_opt) + int'(cfg_sigma);
    risky = (int'(v0) >= lo) && (int'(v0) <= hi);
    drop = (v0 > v1) ? int'(v0) - int'(v1) : 0;
    if (v0 >= cfg_opt)      plain = 2'b01;
    else if (v0 >= cfg_ref_mid) plain = 2'b00;
    else if (v0 >= cfg_ref_lo)  plain = 2'b10;
    else                    plain = 2'b11;
    code = risky ? ((drop > int'(cfg_drop_thr)) ? 2'b01 : 2'b00) : plain;
    return {risky && (code != plain), risky, code};
  endfunction

  task automatic drive();
    for (int i = 0; i < ncell; i++) begin
      @(negedge clk);
      if (stall != 0 && (i % 4) == 3) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1; in_v0 = cv0[i]; in_v1 = cv1[i]; in_last = clast[i];
      #2;
      while (!in_ready) begin
        @(negedge clk);
        #2;
      end
      acc_cyc[i] = cyc;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic collect(input string req);
    int got = 0;
    bit pend = 0;
    bit hold = 0;
    int pr = 0, pm = 0, er = 0, em = 0;
    logic [4:0] held = '0;
    logic [3:0] e;
    while (got < ncell || pend) begin
      @(negedge clk);
      out_ready = (stall == 0) || ((cyc % 3) != 0);
      #2;
      if (pend) begin
        chk(rpt_valid == 1'b1, "R7", "rpt_valid", int'(rpt_valid), 1);
        chk(int'(rpt_risky) == pr, "R7", "rpt_risky", int'(rpt_risky), pr);
        chk(int'(rpt_moved) == pm, "R7", "rpt_moved", int'(rpt_moved), pm);
        pend = 0;
      end else begin
        chk(rpt_valid == 1'b0, "R7", "rpt_valid idle", int'(rpt_valid), 0);
      end
      if (hold) begin
        chk(out_valid && ({out_code, out_risky, out_moved, out_last} == held),
            "R6", "stalled payload", int'({out_code, out_risky, out_moved, out_last}), int'(held));
      end
      hold = out_valid && !out_ready;
      held = {out_code, out_risky, out_moved, out_last};
      if (out_valid && out_ready) begin
        e = model(cv0[got], cv1[got]);
        chk(out_code == e[1:0], req, "code", int'(out_code), int'(e[1:0]));
        chk(out_risky == e[2], req, "risky", int'(out_risky), int'(e[2]));
        chk(out_moved == e[3], "R7", "moved", int'(out_moved), int'(e[3]));
        chk(out_last == clast[got], "R5", "last/order", int'(out_last), int'(clast[got]));
        if (stall == 0)
          chk(cyc - acc_cyc[got] == ST, "R5", "latency", cyc - acc_cyc[got], ST);
        if (e[2]) er = (er == CMAX) ? CMAX : er + 1;
        if (e[3]) em = (em == CMAX) ? CMAX : em + 1;
        if (clast[got]) begin
          pr = er; pm = em; pend = 1; er = 0; em = 0;
        end
        got++;
      end
    end
    out_ready = 1'b1;
  endtask

  task automatic run_stream(input string req);
    fork
      drive();
      collect(req);
    join
  endtask

  task automatic set_cfg(input int lo, input int mid, input int opt, input int sg, input int thr);
    @(negedge clk);
    cfg_ref_lo = VW'(lo); cfg_ref_mid = VW'(mid); cfg_opt = VW'(opt);
    cfg_sigma = VW'(sg); cfg_drop_thr = VW'(thr);
  endtask

  task automatic put(input int i, input int v0, input int v1, input bit l);
    cv0[i] = VW'(v0); cv1[i] = VW'(v1); clast[i] = l;
  endtask

  task automatic t_reset();
    @(negedge clk);
    #2;
    chk(out_valid == 1'b0, "R9", "out_valid", int'(out_valid), 0);
    chk(rpt_valid == 1'b0, "R9", "rpt_valid", int'(rpt_valid), 0);
    chk(in_ready == 1'b1, "R9", "in_ready", int'(in_ready), 1);
    chk(rpt_risky == '0 && rpt_moved == '0, "R9", "rpt counts", int'(rpt_risky) + int'(rpt_moved), 0);
  endtask

  // R1: plain comparison at each reference edge, no drop
  task automatic t_plain();
    int v[8] = '{0, 59, 60, 119, 120, 169, 191, 255};
    set_cfg(60, 120, 180, 10, 8);
    for (int i = 0; i < 8; i++) put(i, v[i], v[i], i == 7);
    ncell = 8; stall = 0;
    run_stream("R1");
  endtask

  // R2/R3/R4: band edges and drop around the threshold
  task automatic t_band();
    set_cfg(60, 120, 180, 10, 8);
    put(0, 170, 170, 0);  // lower edge, slow
    put(1, 190, 190, 0);  // upper edge, slow, moved
    put(2, 169, 100, 0);  // just below band
    put(3, 191, 100, 0);  // just above band
    put(4, 185, 177, 0);  // drop equals threshold: R3
    put(5, 185, 176, 0);  // drop above threshold: R4
    put(6, 172, 163, 0);  // fast below centre, moved: R4
    put(7, 172, 200, 1);  // rising sample counts as slow: R3
    ncell = 8; stall = 0;
    run_stream("R2/R3/R4");
  endtask

  // R2: band bounds clipped at both ends of the code range
  task automatic t_clip();
    set_cfg(60, 120, 250, 10, 8);
    put(0, 255, 255, 0); put(1, 239, 239, 1);
    ncell = 2; stall = 0;
    run_stream("R2");
    set_cfg(1, 3, 5, 10, 8);
    put(0, 0, 0, 0); put(1, 16, 16, 0); put(2, 15, 2, 1);
    ncell = 3; stall = 0;
    run_stream("R2");
  endtask

  // R5/R6: irregular sink readiness and source gaps
  task automatic t_backpressure();
    set_cfg(60, 120, 180, 10, 8);
    for (int i = 0; i < 24; i++)
      put(i, 150 + (i * 7) % 50, 150 + (i * 7) % 50 - (i % 3) * 6, i == 11 || i == 23);
    ncell = 24; stall = 1;
    run_stream("R5/R6");
  endtask

  // R7: one-cell pages back to back
  task automatic t_single_pages();
    set_cfg(60, 120, 180, 10, 8);
    put(0, 175, 150, 1); put(1, 50, 50, 1); put(2, 188, 188, 1);
    put(3, 171, 171, 1); put(4, 200, 150, 1); put(5, 182, 170, 1);
    ncell = 6; stall = 0;
    run_stream("R7");
  endtask

  // R8: more moved cells in one page than the counters hold
  task automatic t_saturate();
    set_cfg(60, 120, 180, 10, 8);
    for (int i = 0; i < 20; i++) put(i, 175, 160, i == 19);
    ncell = 20; stall = 0;
    run_stream("R8");
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_v0 = '0; in_v1 = '0; in_last = 1'b0; out_ready = 1'b1;
    cfg_ref_lo = 8'd60; cfg_ref_mid = 8'd120; cfg_opt = 8'd180; cfg_sigma = 8'd10; cfg_drop_thr = 8'd8;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_plain();
    t_band();
    t_clip();
    t_backpressure();
    t_single_pages();
    t_saturate();
    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule